// File: doc/BRIEF.md
# CCD Readout Clock Sequencer

This block drives the transfer clocks of a full-frame CCD image sensor and turns the digitised pixel values into a tagged stream. A one-cycle start command launches a frame. The block first waits through an exposure window whose length in clocks comes from an input. It then reads the array one row at a time. Each row begins with a single vertical transfer pulse, which moves every column down by one pixel into the serial register. A train of horizontal pulses follows, one for each column, and shifts that register out.

A convert strobe to an external ADC fires a fixed number of clocks after every horizontal rising edge. On the next clock the 16-bit conversion result is captured into the output stream. Each output pixel carries its row and column index, a first-of-frame flag and an end-of-row flag. The pulse widths, the idle gap after a vertical pulse and the convert delay are design-time parameters. The exposure length and the row and column counts are latched when a frame is accepted.

Top module: `ccd_seq_top`

## Requirements
- R1: `busy` rises on the clock after an accepted `start`. The first vertical pulse goes high exactly max(`int_len`,1) clocks after `busy` rises, and no vertical or horizontal pulse occurs before it.
- R2: Each vertical pulse stays high for V_W clocks. `v_clk` and `h_clk` are never high in the same cycle.
- R3: After each vertical pulse falls, `h_clk` stays low for exactly V_GAP clocks (V_GAP at least 1) before the first horizontal pulse of that row.
- R4: Every horizontal pulse is high for H_W clocks and then low for H_W clocks. A row has exactly the latched column count of horizontal pulses. The next vertical pulse rises right after the low phase of the last horizontal pulse.
- R5: A frame has exactly the latched row count of vertical pulses and rows*columns horizontal pulses. A row or column count of zero is taken as one.
- R6: `adc_conv` is a one-cycle strobe that goes high exactly ADC_DLY clocks after each `h_clk` rising edge.
- R7: `pix_valid` is high for one cycle, on the clock after each `adc_conv`. `pix_data` equals the 16-bit `adc_data` present during the `adc_conv` cycle, across the full range 0 to 65535.
- R8: Pixels come out in row-major order with 0-based `pix_row` and `pix_col`. `pix_sof` is set only on row 0, column 0. `pix_eol` is set only on the last column of each row.
- R9: A `start` while `busy` is high is ignored, and changes to `rows`, `cols` or `int_len` during a frame have no effect on that frame.
- R10: `busy` stays high through the cycle of the frame's last `pix_valid` and is low on the following cycle.
- R11: While reset is applied, `busy`, `v_clk`, `h_clk`, `adc_conv` and `pix_valid` are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Frame start command, sampled while idle |
| int_len | input | INT_W | Exposure length in clocks |
| rows | input | ROW_W | Number of rows to read |
| cols | input | COL_W | Number of columns per row |
| v_clk | output | 1 | Vertical (parallel) transfer pulse |
| h_clk | output | 1 | Horizontal (serial) transfer pulse |
| adc_conv | output | 1 | ADC convert strobe |
| adc_data | input | DATA_W | ADC conversion result |
| pix_valid | output | 1 | Pixel stream valid |
| pix_data | output | DATA_W | Captured pixel value |
| pix_row | output | ROW_W | Row index of the pixel |
| pix_col | output | COL_W | Column index of the pixel |
| pix_sof | output | 1 | First pixel of frame |
| pix_eol | output | 1 | Last pixel of a row |
| busy | output | 1 | Frame in progress |

## Verification
The main test is a frame with several rows, several columns and a long exposure. It checks how row and column pulses nest, and it checks the gap and pulse-width timing at every boundary. A single-pixel frame with zero exposure checks the minimum exposure length and a row that is both first and last. A single-column frame and a frame with a zero row count check the end-of-row and end-of-frame decisions, which are easy to get off by one. A frame that receives a second start and new dimensions in the middle shows that the latched settings hold and that the extra start is dropped. The ADC model returns full-scale, zero and scattered values, so the scoreboard can tell a missed or shifted capture from a correct one.

// File: rtl/ccd_seq_pkg.sv
package ccd_seq_pkg;

  // Readout phases of the sequencer
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_INTEG,
    ST_VPUL,
    ST_VGAP,
    ST_HPUL,
    ST_HLOW
  } seq_state_e;

endpackage

// File: rtl/ccd_seq_rst_sync.sv
module ccd_seq_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_sync_n = sync_q[1];

endmodule

// File: rtl/ccd_seq_ctrl.sv
module ccd_seq_ctrl
  import ccd_seq_pkg::*;
#(
  parameter int ROW_W = 12,
  parameter int COL_W = 12,
  parameter int INT_W = 20,
  parameter int V_W   = 4,
  parameter int H_W   = 2,
  parameter int V_GAP = 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             samp_pend,
  input  logic [INT_W-1:0] int_len,
  input  logic [ROW_W-1:0] rows,
  input  logic [COL_W-1:0] cols,
  output logic             v_clk,
  output logic             h_clk,
  output logic             active,
  output logic             ev_valid,
  output logic [ROW_W-1:0] ev_row,
  output logic [COL_W-1:0] ev_col,
  output logic             ev_sof,
  output logic             ev_eol
);

  localparam int VH_MAX = (V_W > H_W) ? V_W : H_W;
  localparam int PH_MAX = (VH_MAX > V_GAP) ? VH_MAX : V_GAP;
  localparam int PH_W   = $clog2(PH_MAX + 1);
  localparam int CW     = (INT_W > PH_W) ? INT_W : PH_W;

  seq_state_e       state_q, state_d;
  logic [CW-1:0]    tcnt_q, tcnt_d;
  logic [ROW_W-1:0] row_q, row_d, rows_q;
  logic [COL_W-1:0] col_q, col_d, cols_q;
  logic             accept, last_col, last_row;

  assign accept   = (state_q == ST_IDLE) && start && !samp_pend;
  assign last_col = (col_q == cols_q - COL_W'(1));
  assign last_row = (row_q == rows_q - ROW_W'(1));

  always_comb begin
    state_d  = state_q;
    tcnt_d   = tcnt_q;
    row_d    = row_q;
    col_d    = col_q;
    ev_valid = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (accept) begin
          state_d = ST_INTEG;
          tcnt_d  = (int_len == '0) ? '0 : CW'(int_len) - CW'(1);
          row_d   = '0;
          col_d   = '0;
        end
      end
      ST_INTEG: begin
        if (tcnt_q == '0) begin
          state_d = ST_VPUL;
          tcnt_d  = CW'(V_W - 1);
        end else tcnt_d = tcnt_q - CW'(1);
      end
      ST_VPUL: begin
        if (tcnt_q == '0) begin
          state_d = ST_VGAP;
          tcnt_d  = CW'(V_GAP - 1);
        end else tcnt_d = tcnt_q - CW'(1);
      end
      ST_VGAP: begin
        if (tcnt_q == '0) begin
          state_d  = ST_HPUL;
          tcnt_d   = CW'(H_W - 1);
          col_d    = '0;
          ev_valid = 1'b1;
        end else tcnt_d = tcnt_q - CW'(1);
      end
      ST_HPUL: begin
        if (tcnt_q == '0) begin
          state_d = ST_HLOW;
          tcnt_d  = CW'(H_W - 1);
        end else tcnt_d = tcnt_q - CW'(1);
      end
      ST_HLOW: begin
        if (tcnt_q == '0) begin
          if (!last_col) begin
            state_d  = ST_HPUL;
            tcnt_d   = CW'(H_W - 1);
            col_d    = col_q + COL_W'(1);
            ev_valid = 1'b1;
          end else if (!last_row) begin
            state_d = ST_VPUL;
            tcnt_d  = CW'(V_W - 1);
            row_d   = row_q + ROW_W'(1);
          end else begin
            state_d = ST_IDLE;
          end
        end else tcnt_d = tcnt_q - CW'(1);
      end
      default: state_d = ST_IDLE;
    endcase
  end

  // Tag of the pixel whose serial shift begins on this edge
  assign ev_row = row_q;
  assign ev_col = col_d;
  assign ev_sof = (row_q == '0) && (col_d == '0);
  assign ev_eol = (col_d == cols_q - COL_W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      tcnt_q  <= '0;
      row_q   <= '0;
      col_q   <= '0;
    end else begin
      state_q <= state_d;
      tcnt_q  <= tcnt_d;
      row_q   <= row_d;
      col_q   <= col_d;
    end
  end

  // Frame dimensions: clock-enabled on frame acceptance only
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rows_q <= ROW_W'(1);
      cols_q <= COL_W'(1);
    end else if (accept) begin
      rows_q <= (rows == '0) ? ROW_W'(1) : rows;
      cols_q <= (cols == '0) ? COL_W'(1) : cols;
    end
  end

  assign v_clk  = (state_q == ST_VPUL);
  assign h_clk  = (state_q == ST_HPUL);
  assign active = (state_q != ST_IDLE);

endmodule

// File: rtl/ccd_seq_sample.sv
module ccd_seq_sample #(
  parameter int ROW_W   = 12,
  parameter int COL_W   = 12,
  parameter int DATA_W  = 16,
  parameter int ADC_DLY = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ev_valid,
  input  logic [ROW_W-1:0]  ev_row,
  input  logic [COL_W-1:0]  ev_col,
  input  logic              ev_sof,
  input  logic              ev_eol,
  input  logic [DATA_W-1:0] adc_data,
  output logic              adc_conv,
  output logic              pend,
  output logic              pix_valid,
  output logic [DATA_W-1:0] pix_data,
  output logic [ROW_W-1:0]  pix_row,
  output logic [COL_W-1:0]  pix_col,
  output logic              pix_sof,
  output logic              pix_eol
);

  localparam int NST = ADC_DLY + 1;

  logic [NST-1:0]   vld_q;
  logic [ROW_W-1:0] row_p [NST];
  logic [COL_W-1:0] col_p [NST];
  logic [NST-1:0]   sof_p, eol_p;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) vld_q <= '0;
    else        vld_q <= {vld_q[NST-2:0], ev_valid};
  end

  // Tag stage 0 captures the event, later stages follow the valid bits
  always_ff @(posedge clk) begin
    if (ev_valid) begin
      row_p[0] <= ev_row;
      col_p[0] <= ev_col;
      sof_p[0] <= ev_sof;
      eol_p[0] <= ev_eol;
    end
  end

  for (genvar g = 1; g < NST; g++) begin : g_tag
    always_ff @(posedge clk) begin
      if (vld_q[g-1]) begin
        row_p[g] <= row_p[g-1];
        col_p[g] <= col_p[g-1];
        sof_p[g] <= sof_p[g-1];
        eol_p[g] <= eol_p[g-1];
      end
    end
  end

  assign adc_conv = vld_q[NST-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pix_valid <= 1'b0;
      pix_sof   <= 1'b0;
      pix_eol   <= 1'b0;
    end else begin
      pix_valid <= adc_conv;
      pix_sof   <= adc_conv && sof_p[NST-1];
      pix_eol   <= adc_conv && eol_p[NST-1];
    end
  end

  always_ff @(posedge clk) begin
    if (adc_conv) begin
      pix_data <= adc_data;
      pix_row  <= row_p[NST-1];
      pix_col  <= col_p[NST-1];
    end
  end

  assign pend = (|vld_q) | pix_valid;

endmodule

// File: rtl/ccd_seq_top.sv
module ccd_seq_top #(
  parameter int ROW_W   = 12,
  parameter int COL_W   = 12,
  parameter int INT_W   = 20,
  parameter int DATA_W  = 16,
  parameter int V_W     = 4,
  parameter int H_W     = 2,
  parameter int V_GAP   = 1,
  parameter int ADC_DLY = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [INT_W-1:0]  int_len,
  input  logic [ROW_W-1:0]  rows,
  input  logic [COL_W-1:0]  cols,
  output logic              v_clk,
  output logic              h_clk,
  output logic              adc_conv,
  input  logic [DATA_W-1:0] adc_data,
  output logic              pix_valid,
  output logic [DATA_W-1:0] pix_data,
  output logic [ROW_W-1:0]  pix_row,
  output logic [COL_W-1:0]  pix_col,
  output logic              pix_sof,
  output logic              pix_eol,
  output logic              busy
);

  logic             rst_int_n;
  logic             samp_pend, ctrl_active;
  logic             ev_valid, ev_sof, ev_eol;
  logic [ROW_W-1:0] ev_row;
  logic [COL_W-1:0] ev_col;

  ccd_seq_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_int_n)
  );

  ccd_seq_ctrl #(
    .ROW_W (ROW_W),
    .COL_W (COL_W),
    .INT_W (INT_W),
    .V_W   (V_W),
    .H_W   (H_W),
    .V_GAP (V_GAP)
  ) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .start     (start),
    .samp_pend (samp_pend),
    .int_len   (int_len),
    .rows      (rows),
    .cols      (cols),
    .v_clk     (v_clk),
    .h_clk     (h_clk),
    .active    (ctrl_active),
    .ev_valid  (ev_valid),
    .ev_row    (ev_row),
    .ev_col    (ev_col),
    .ev_sof    (ev_sof),
    .ev_eol    (ev_eol)
  );

  ccd_seq_sample #(
    .ROW_W   (ROW_W),
    .COL_W   (COL_W),
    .DATA_W  (DATA_W),
    .ADC_DLY (ADC_DLY)
  ) u_samp (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .ev_valid  (ev_valid),
    .ev_row    (ev_row),
    .ev_col    (ev_col),
    .ev_sof    (ev_sof),
    .ev_eol    (ev_eol),
    .adc_data  (adc_data),
    .adc_conv  (adc_conv),
    .pend      (samp_pend),
    .pix_valid (pix_valid),
    .pix_data  (pix_data),
    .pix_row   (pix_row),
    .pix_col   (pix_col),
    .pix_sof   (pix_sof),
    .pix_eol   (pix_eol)
  );

  assign busy = ctrl_active | samp_pend;

endmodule

// File: rtl/ccd_seq_chk.sv
module ccd_seq_chk (
  input logic clk,
  input logic rst_n,
  input logic v_clk,
  input logic h_clk,
  input logic adc_conv,
  input logic pix_valid,
  input logic pix_sof,
  input logic pix_eol,
  input logic busy
);

  a_r1_quiet_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!v_clk && !h_clk && !adc_conv && !pix_valid));

  a_r2_no_overlap: assert property (@(posedge clk) disable iff (!rst_n)
    !(v_clk && h_clk));

  a_r3_gap_before_h: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(h_clk) |-> !$past(v_clk));

  a_r6_conv_single: assert property (@(posedge clk) disable iff (!rst_n)
    adc_conv |=> !adc_conv);

  a_r7_valid_follows_conv: assert property (@(posedge clk) disable iff (!rst_n)
    pix_valid |-> $past(adc_conv));

  a_r8_flags_qualified: assert property (@(posedge clk) disable iff (!rst_n)
    (pix_sof || pix_eol) |-> pix_valid);

  a_r10_busy_ends_on_pixel: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> $past(pix_valid));

endmodule

bind ccd_seq_top ccd_seq_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .v_clk     (v_clk),
  .h_clk     (h_clk),
  .adc_conv  (adc_conv),
  .pix_valid (pix_valid),
  .pix_sof   (pix_sof),
  .pix_eol   (pix_eol),
  .busy      (busy)
);

// File: tb/ccd_seq_top_tb_top.sv
module ccd_seq_top_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int ROW_W = 12, COL_W = 12, INT_W = 20, DATA_W = 16;
  localparam int V_W = 3, H_W = 2, V_GAP = 2, ADC_DLY = 3;
  localparam int WD_CYCLES = 150000;

  typedef struct packed {
    int  data;
    int  row;
    int  col;
    bit  sof;
    bit  eol;
  } pix_t;

  logic              clk = 1'b0;
  logic              rst_n;
  logic              start;
  logic [INT_W-1:0]  int_len;
  logic [ROW_W-1:0]  rows;
  logic [COL_W-1:0]  cols;
  logic              v_clk, h_clk, adc_conv, pix_valid, pix_sof, pix_eol, busy;
  logic [DATA_W-1:0] adc_data;
  logic [DATA_W-1:0] pix_data;
  logic [ROW_W-1:0]  pix_row;
  logic [COL_W-1:0]  pix_col;

  int checks = 0, errors = 0;
  int k_exp = 0, k_adc = 0;
  int exp_int, exp_rows, exp_cols;
  bit mon_en = 0, done = 0;
  pix_t exp_q[$];
  int   hrise_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  ccd_seq_top #(
    .ROW_W(ROW_W), .COL_W(COL_W), .INT_W(INT_W), .DATA_W(DATA_W),
    .V_W(V_W), .H_W(H_W), .V_GAP(V_GAP), .ADC_DLY(ADC_DLY)
  ) dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .int_len(int_len),
    .rows(rows), .cols(cols), .v_clk(v_clk), .h_clk(h_clk),
    .adc_conv(adc_conv), .adc_data(adc_data), .pix_valid(pix_valid),
    .pix_data(pix_data), .pix_row(pix_row), .pix_col(pix_col),
    .pix_sof(pix_sof), .pix_eol(pix_eol), .busy(busy)
  );

  function automatic logic [15:0] adc_val(int k);
    if (k == 0) return 16'hFFFF;
    if (k == 1) return 16'h0000;
    return 16'((k * 40503 + 7));
  endfunction

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // ADC model: returns the next sample in the convert cycle
  always @(negedge clk) begin
    if (adc_conv) begin
      adc_data = adc_val(k_adc);
      k_adc++;
    end
  end

  // Monitor: timing checks and scoreboard comparison
  int  cyc = 0, t_busy, t_vfall, t_hfall, v_start, h_start;
  int  v_cnt, h_cnt, h_in_row;
  bit  first_v = 0, prev_busy = 0, prev_v = 0, prev_h = 0, prev_conv = 0, prev_pix = 0;

  always @(negedge clk) begin
    cyc++;
    if (mon_en) begin
      if (busy && !prev_busy) begin
        t_busy = cyc; v_cnt = 0; h_cnt = 0; h_in_row = 0; first_v = 1;
      end
      if (v_clk && !prev_v) begin
        if (first_v) begin
          chk("R1 integration length", cyc - t_busy, exp_int);
          chk("R1 no h pulse during integration", h_cnt, 0);
          first_v = 0;
        end else begin
          chk("R4 h pulses per row", h_in_row, exp_cols);
          chk("R4 v after last h low phase", cyc - t_hfall, H_W);
        end
        v_cnt++; h_in_row = 0; v_start = cyc;
      end
      if (!v_clk && prev_v) begin
        chk("R2 v pulse width", cyc - v_start, V_W);
        t_vfall = cyc;
      end
      if (h_clk && !prev_h) begin
        if (h_in_row == 0) chk("R3 v to h gap", cyc - t_vfall, V_GAP);
        else               chk("R4 h low width", cyc - t_hfall, H_W);
        chk("R2 h not with v", int'(v_clk), 0);
        h_cnt++; h_in_row++; h_start = cyc;
        hrise_q.push_back(cyc);
      end
      if (!h_clk && prev_h) begin
        chk("R4 h high width", cyc - h_start, H_W);
        t_hfall = cyc;
      end
      if (adc_conv) begin
        if (hrise_q.size() == 0) chk("R6 conv without h edge", 1, 0);
        else chk("R6 conv delay", cyc - hrise_q.pop_front(), ADC_DLY);
      end
      if (pix_valid) begin
        pix_t e;
        chk("R7 valid one after conv", int'(prev_conv), 1);
        if (exp_q.size() == 0) chk("R8 unexpected pixel", 1, 0);
        else begin
          e = exp_q.pop_front();
          chk("R7 pixel data", int'(pix_data), e.data);
          chk("R8 pixel row", int'(pix_row), e.row);
          chk("R8 pixel col", int'(pix_col), e.col);
          chk("R8 sof flag", int'(pix_sof), int'(e.sof));
          chk("R8 eol flag", int'(pix_eol), int'(e.eol));
        end
      end
      if (!busy && prev_busy) begin
        chk("R10 busy held to last pixel", int'(prev_pix), 1);
        chk("R5 v pulse count", v_cnt, exp_rows);
        chk("R5 h pulse count", h_cnt, exp_rows * exp_cols);
        chk("R8 pixels outstanding", exp_q.size(), 0);
      end
    end
    prev_busy = busy; prev_v = v_clk; prev_h = h_clk;
    prev_conv = adc_conv; prev_pix = pix_valid;
  end

  // Driver: queues expected pixels, then issues the frame
  task automatic run_frame(int t, int r, int c, bit disturb);
    int er, ec;
    er = (r == 0) ? 1 : r;
    ec = (c == 0) ? 1 : c;
    exp_int = (t == 0) ? 1 : t;
    exp_rows = er;
    exp_cols = ec;
    for (int rr = 0; rr < er; rr++) begin
      for (int cc = 0; cc < ec; cc++) begin
        pix_t p;
        p.data = int'(adc_val(k_exp));
        p.row = rr; p.col = cc;
        p.sof = (rr == 0 && cc == 0);
        p.eol = (cc == ec - 1);
        exp_q.push_back(p);
        k_exp++;
      end
    end
    @(negedge clk);
    int_len = INT_W'(t); rows = ROW_W'(r); cols = COL_W'(c); start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk("R1 busy after start", int'(busy), 1);
    if (disturb) begin
      repeat (exp_int + 6) @(negedge clk);
      int_len = 20'd1; rows = 12'd7; cols = 12'd9; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
    end
    while (busy) @(negedge clk);
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      chk("R9 no late frame from ignored start", int'(busy), 0);
    end
  endtask

  initial begin
    rst_n = 1'b0; start = 1'b0; int_len = '0; rows = '0; cols = '0;
    adc_data = '0;
    repeat (3) @(negedge clk);
    chk("R11 busy in reset", int'(busy), 0);
    chk("R11 v_clk in reset", int'(v_clk), 0);
    chk("R11 h_clk in reset", int'(h_clk), 0);
    chk("R11 adc_conv in reset", int'(adc_conv), 0);
    chk("R11 pix_valid in reset", int'(pix_valid), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    mon_en = 1;
    run_frame(12, 3, 4, 1'b0);  // multi-row, multi-column, long exposure
    run_frame(0, 1, 1, 1'b0);   // single pixel, zero exposure
    run_frame(1, 4, 1, 1'b0);   // single column
    run_frame(3, 0, 3, 1'b0);   // zero row count taken as one
    run_frame(2, 2, 3, 1'b1);   // R9: start and new sizes mid-frame
    repeat (5) @(negedge clk);
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (WD_CYCLES) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog: actual %0d expected %0d", WD_CYCLES, 0);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule